// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the configuration register file of a twenty-channel DMA engine. Software reaches it through a simple strobe-based register port. Every channel has its own copy of control, descriptor base, descriptor count, interrupt status and interrupt enable. These copies are not mapped side by side in the address space. A channel-select register chooses which copy a fixed window of offsets reaches. The remaining registers are shared by all channels:
- a per-channel gate on the interrupt line;
- a descriptor-polling setup;
- a port-select register with a port-control register banked per port;
- an engine-wide reset trigger.

Each channel's settings go out on flat vector ports to the channel datapaths, and those datapaths return a one-cycle descriptor-done pulse per channel. The block keeps a per-channel descriptor index that wraps at the programmed count. A channel soft reset runs for a fixed number of cycles and clears itself. The status of all channels merges into one registered interrupt line. The register port is plain control: a write or read strobe is taken on every clock edge where it is high, with no back-pressure. Read data returns on the next cycle, qualified by a valid flag.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, every channel output is zero and the interrupt line is low.
- R2: The channel select at offset 0x18 keeps the low 5 bits written and reads them back. With a value below 20, offsets 0x1C to 0x2C reach that channel's copy. With 20 or more, writes to those offsets change nothing and reads of them return zero.
- R3: The channel control at 0x1C keeps bit 0 (channel on), bit 8 (transmit direction) and bits 17:16 (arbitration weight) and drives them out. All other bits read zero, except bit 1 as defined in R4.
- R4: Writing control with bit 1 set starts a channel reset. Bit 1 and the busy output stay high for exactly 4 cycles after the write edge, then drop. At completion the channel-on bit, the interrupt status and the descriptor index are cleared. Direction and weight are kept. Control writes made while the reset is busy are ignored.
- R5: A descriptor-done pulse on a channel whose channel-on bit is set sets bit 3 of its status at 0x28. Writing the status register clears every set status bit that has a 1 in the write data within mask 0x7E. Write-data bits outside that mask have no effect.
- R6: The interrupt enable at 0x2C keeps bits 7:0. The global enable at 0xF4 keeps one bit per channel. One cycle after the state changes, the interrupt output equals the OR over all channels n of (status AND enable) that are nonzero, gated by global bit n.
- R7: The descriptor count at 0x24 keeps bits 15:0. Each accepted done pulse advances the channel's index, which returns to 0 when it reaches the count. With a count of 0 the index stays 0.
- R8: The descriptor base at 0x20 keeps all 32 bits and drives them out.
- R9: The polling register at 0x14 keeps only bit 31 (poll enable) and bit 6 (divide-by-4 poll clock), and drives both out.
- R10: Writing 1 to bit 0 of 0x10 clears every channel copy, including any reset in progress, and the global enable one cycle after the write edge. Bit 0 reads zero once the clear is done.
- R11: The port select at 0x40 keeps 3 bits. With a value below 5, the control at 0x44 reaches that port's copy. Otherwise 0x44 ignores writes and reads zero.
- R12: Read data and its valid flag appear on the cycle after the read strobe. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Marks rdata valid |
| desc_done | input | 20 | Per-channel descriptor-complete pulse |
| chan_on | output | 20 | Channel enabled |
| chan_tx | output | 20 | Channel is transmit |
| chan_weight | output | 40 | Arbitration weight, 2 bits per channel |
| chan_base | output | 640 | Descriptor base, 32 bits per channel |
| chan_count | output | 320 | Descriptor count, 16 bits per channel |
| chan_idx | output | 320 | Current descriptor index, 16 bits per channel |
| chan_rst_busy | output | 20 | Channel reset in progress |
| poll_en | output | 1 | Descriptor polling on |
| poll_div4 | output | 1 | Poll clock divided by 4 |
| port_ctrl | output | 160 | Port control, 32 bits per port |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a channel reset that lands on a channel holding pending status, a nonzero descriptor index and a control write arriving in the middle of its busy window. The stimulus first turns a channel on and advances its index with done pulses. It then requests the reset, checks the busy flag on each of the following cycles, and in a second run issues a control write inside the busy window to show that the write has no effect. An out-of-range channel select is also driven, and the bench confirms that a write through it leaves the previously selected channel intact.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam logic [7:0] OFS_GCTRL = 8'h10;
  localparam logic [7:0] OFS_POLL  = 8'h14;
  localparam logic [7:0] OFS_CSEL  = 8'h18;
  localparam logic [7:0] OFS_CCTRL = 8'h1C;
  localparam logic [7:0] OFS_CBASE = 8'h20;
  localparam logic [7:0] OFS_CCNT  = 8'h24;
  localparam logic [7:0] OFS_CSTAT = 8'h28;
  localparam logic [7:0] OFS_CIEN  = 8'h2C;
  localparam logic [7:0] OFS_PSEL  = 8'h40;
  localparam logic [7:0] OFS_PCTRL = 8'h44;
  localparam logic [7:0] OFS_GIEN  = 8'hF4;

  localparam int STAT_W   = 8;
  localparam int DONE_BIT = 3;
  localparam logic [STAT_W-1:0] ACK_MASK = 8'h7E;

  typedef enum logic [2:0] {
    SLOT_NONE, SLOT_CTRL, SLOT_BASE, SLOT_CNT, SLOT_STAT, SLOT_IEN
  } chan_slot_e;
endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  chan_slot_e        slot,
  input  logic [31:0]       wdata,
  input  logic              done_evt,
  output logic              on,
  output logic              tx,
  output logic [1:0]        weight,
  output logic              busy,
  output logic [31:0]       base,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  idx,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] ien
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0]   rcnt;
  logic              take_done;
  logic [CNT_W-1:0]  idx_next;
  logic [STAT_W-1:0] stat_ack;

  assign take_done = done_evt && on && !busy;
  assign idx_next  = (count == '0) ? '0 :
                     ((idx + 1'b1) >= count) ? '0 : idx + 1'b1;
  assign stat_ack  = (wr && slot == SLOT_STAT) ? (wdata[STAT_W-1:0] & ACK_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on <= 1'b0; tx <= 1'b0; weight <= '0; busy <= 1'b0; rcnt <= '0;
      base <= '0; count <= '0; idx <= '0; stat <= '0; ien <= '0;
    end else if (clr) begin
      on <= 1'b0; tx <= 1'b0; weight <= '0; busy <= 1'b0; rcnt <= '0;
      base <= '0; count <= '0; idx <= '0; stat <= '0; ien <= '0;
    end else begin
      if (busy) begin
        rcnt <= rcnt - 1'b1;
        if (rcnt == RC_W'(1)) begin
          busy <= 1'b0;
          on   <= 1'b0;
          stat <= '0;
          idx  <= '0;
        end
      end else begin
        if (wr && slot == SLOT_CTRL) begin
          on     <= wdata[0];
          tx     <= wdata[8];
          weight <= wdata[17:16];
          if (wdata[1]) begin
            busy <= 1'b1;
            rcnt <= RC_W'(RST_CYC);
          end
        end
        if (take_done) idx <= idx_next;
        stat <= (stat & ~stat_ack) | (take_done ? STAT_W'(1) << DONE_BIT : '0);
      end
      if (wr && slot == SLOT_BASE) base  <= wdata;
      if (wr && slot == SLOT_CNT)  count <= wdata[CNT_W-1:0];
      if (wr && slot == SLOT_IEN)  ien   <= wdata[STAT_W-1:0];
    end
  end

  // checker window counter
  logic [RC_W+1:0] chk_busy;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_busy <= '0;
    else if (busy) chk_busy <= chk_busy + 1'b1;
    else chk_busy <= '0;
  end

  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!on && stat == '0 && idx == '0));
  a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    chk_busy <= (RC_W+2)'(RST_CYC));
endmodule

// File: rtl/dma_global_regs.sv
module dma_global_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH   = 20,
  parameter int NPORT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [31:0]         wdata,
  output logic                eng_clr,
  output logic [NCH-1:0]      gen_en,
  output logic                poll_en,
  output logic                poll_div4,
  output logic [$clog2(NPORT)-1:0] psel,
  output logic [NPORT*32-1:0] port_ctrl
);
  localparam int PSW = $clog2(NPORT);

  logic [31:0] pctl [NPORT];
  logic        psel_ok;

  assign psel_ok = (32'(psel) < NPORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_clr <= 1'b0; gen_en <= '0; poll_en <= 1'b0; poll_div4 <= 1'b0; psel <= '0;
    end else begin
      eng_clr <= wr_en && addr == OFS_GCTRL && wdata[0];
      if (eng_clr) gen_en <= '0;
      else if (wr_en && addr == OFS_GIEN) gen_en <= wdata[NCH-1:0];
      if (wr_en && addr == OFS_POLL) begin
        poll_en   <= wdata[31];
        poll_div4 <= wdata[6];
      end
      if (wr_en && addr == OFS_PSEL) psel <= wdata[PSW-1:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pctl[p] <= '0;
      else if (wr_en && addr == OFS_PCTRL && psel_ok && 32'(psel) == p) pctl[p] <= wdata;
    end
    assign port_ctrl[p*32 +: 32] = pctl[p];
  end

  a_r10_gen_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_clr) |-> gen_en == '0);
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
  import dma_regs_pkg::*;
#(
  parameter int NCH = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat [NCH],
  input  logic [STAT_W-1:0] ien  [NCH],
  input  logic [NCH-1:0]    gen_en,
  output logic              irq
);
  logic [NCH-1:0] pend;

  for (genvar n = 0; n < NCH; n++) begin : g_pend
    assign pend[n] = gen_en[n] && ((stat[n] & ien[n]) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= |pend;
  end

  a_r6_irq_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(gen_en != '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH     = 20,
  parameter int NPORT   = 5,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 rd_valid,
  input  logic [NCH-1:0]       desc_done,
  output logic [NCH-1:0]       chan_on,
  output logic [NCH-1:0]       chan_tx,
  output logic [NCH*2-1:0]     chan_weight,
  output logic [NCH*32-1:0]    chan_base,
  output logic [NCH*CNT_W-1:0] chan_count,
  output logic [NCH*CNT_W-1:0] chan_idx,
  output logic [NCH-1:0]       chan_rst_busy,
  output logic                 poll_en,
  output logic                 poll_div4,
  output logic [NPORT*32-1:0]  port_ctrl,
  output logic                 irq
);
  localparam int SELW = $clog2(NCH);
  localparam int PSW  = $clog2(NPORT);

  logic [SELW-1:0]   csel;
  logic              csel_ok;
  logic [SELW-1:0]   csel_idx;
  chan_slot_e        slot;
  logic              eng_clr;
  logic [NCH-1:0]    gen_en;
  logic [PSW-1:0]    psel;
  logic [STAT_W-1:0] stat_a [NCH];
  logic [STAT_W-1:0] ien_a  [NCH];
  logic [31:0]       ctrl_rd [NCH];
  logic [31:0]       base_a  [NCH];
  logic [CNT_W-1:0]  cnt_a   [NCH];
  logic [31:0]       rd_next;

  assign csel_ok  = (32'(csel) < NCH);
  assign csel_idx = csel_ok ? csel : '0;

  always_comb begin
    unique case (addr)
      OFS_CCTRL: slot = SLOT_CTRL;
      OFS_CBASE: slot = SLOT_BASE;
      OFS_CCNT:  slot = SLOT_CNT;
      OFS_CSTAT: slot = SLOT_STAT;
      OFS_CIEN:  slot = SLOT_IEN;
      default:   slot = SLOT_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csel <= '0;
    else if (wr_en && addr == OFS_CSEL) csel <= wdata[SELW-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_chan_bank #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (eng_clr),
      .wr       (wr_en && csel_ok && csel == SELW'(c)),
      .slot     (slot),
      .wdata    (wdata),
      .done_evt (desc_done[c]),
      .on       (chan_on[c]),
      .tx       (chan_tx[c]),
      .weight   (chan_weight[c*2 +: 2]),
      .busy     (chan_rst_busy[c]),
      .base     (base_a[c]),
      .count    (cnt_a[c]),
      .idx      (chan_idx[c*CNT_W +: CNT_W]),
      .stat     (stat_a[c]),
      .ien      (ien_a[c])
    );
    assign chan_base[c*32 +: 32]        = base_a[c];
    assign chan_count[c*CNT_W +: CNT_W] = cnt_a[c];
    assign ctrl_rd[c] = {14'b0, chan_weight[c*2 +: 2], 7'b0, chan_tx[c],
                         6'b0, chan_rst_busy[c], chan_on[c]};
  end

  dma_global_regs #(.NCH(NCH), .NPORT(NPORT)) u_glob (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .eng_clr   (eng_clr),
    .gen_en    (gen_en),
    .poll_en   (poll_en),
    .poll_div4 (poll_div4),
    .psel      (psel),
    .port_ctrl (port_ctrl)
  );

  dma_irq_combine #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat_a),
    .ien    (ien_a),
    .gen_en (gen_en),
    .irq    (irq)
  );

  always_comb begin
    rd_next = '0;
    if (slot != SLOT_NONE) begin
      if (csel_ok) begin
        unique case (slot)
          SLOT_CTRL: rd_next = ctrl_rd[csel_idx];
          SLOT_BASE: rd_next = base_a[csel_idx];
          SLOT_CNT:  rd_next = 32'(cnt_a[csel_idx]);
          SLOT_STAT: rd_next = 32'(stat_a[csel_idx]);
          SLOT_IEN:  rd_next = 32'(ien_a[csel_idx]);
          default:   rd_next = '0;
        endcase
      end
    end else begin
      unique case (addr)
        OFS_GCTRL: rd_next = {31'b0, eng_clr};
        OFS_POLL:  rd_next = {poll_en, 24'b0, poll_div4, 6'b0};
        OFS_CSEL:  rd_next = 32'(csel);
        OFS_GIEN:  rd_next = 32'(gen_en);
        OFS_PSEL:  rd_next = 32'(psel);
        OFS_PCTRL: rd_next = (32'(psel) < NPORT) ? port_ctrl[32'(psel)*32 +: 32] : '0;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_next : '0;
    end
  end

  a_r2_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !csel_ok && slot != SLOT_NONE) |=> rdata == '0);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int PERIOD = 10;
  localparam int NCH = 20, NPORT = 5, CW = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rd_valid, poll_en, poll_div4, irq;
  logic [NCH-1:0] desc_done = 0, chan_on, chan_tx, chan_rst_busy;
  logic [NCH*2-1:0] chan_weight;
  logic [NCH*32-1:0] chan_base;
  logic [NCH*CW-1:0] chan_count, chan_idx;
  logic [NPORT*32-1:0] port_ctrl;

  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_chan_regs uut (.*);

  // {is_read, req number, addr, data or expected}
  localparam int NV = 29;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'd2,  8'h18, 32'h0000_0002},
    {1'b0, 4'd3,  8'h1C, 32'h0003_0101},
    {1'b1, 4'd3,  8'h1C, 32'h0003_0101}, // R3
    {1'b0, 4'd3,  8'h1C, 32'hFFFC_FEFC},
    {1'b1, 4'd3,  8'h1C, 32'h0000_0000}, // R3
    {1'b0, 4'd8,  8'h20, 32'hDEAD_BEEF},
    {1'b1, 4'd8,  8'h20, 32'hDEAD_BEEF}, // R8
    {1'b0, 4'd7,  8'h24, 32'h0001_0003},
    {1'b1, 4'd7,  8'h24, 32'h0000_0003}, // R7
    {1'b0, 4'd6,  8'h2C, 32'hFFFF_FFFF},
    {1'b1, 4'd6,  8'h2C, 32'h0000_00FF}, // R6
    {1'b0, 4'd9,  8'h14, 32'hFFFF_FFFF},
    {1'b1, 4'd9,  8'h14, 32'h8000_0040}, // R9
    {1'b0, 4'd6,  8'hF4, 32'hFFFF_FFFF},
    {1'b1, 4'd6,  8'hF4, 32'h000F_FFFF}, // R6
    {1'b0, 4'd2,  8'h18, 32'h0000_0019},
    {1'b1, 4'd2,  8'h18, 32'h0000_0019}, // R2
    {1'b0, 4'd2,  8'h20, 32'h1111_1111},
    {1'b1, 4'd2,  8'h20, 32'h0000_0000}, // R2
    {1'b0, 4'd2,  8'h18, 32'h0000_0002},
    {1'b1, 4'd2,  8'h20, 32'hDEAD_BEEF}, // R2
    {1'b1, 4'd12, 8'h30, 32'h0000_0000}, // R12
    {1'b0, 4'd11, 8'h40, 32'h0000_0001},
    {1'b0, 4'd11, 8'h44, 32'h0000_1234},
    {1'b1, 4'd11, 8'h44, 32'h0000_1234}, // R11
    {1'b0, 4'd11, 8'h40, 32'h0000_0005},
    {1'b1, 4'd11, 8'h44, 32'h0000_0000}, // R11
    {1'b0, 4'd11, 8'h40, 32'h0000_0001},
    {1'b1, 4'd11, 8'h44, 32'h0000_1234}  // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 0; d = rdata;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R12: rd_valid got %b expected 1", rd_valid);
    end
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); desc_done[ch] = 1;
    @(posedge clk);
    @(negedge clk); desc_done[ch] = 0;
  endtask

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 chan_on", 32'(chan_on), 0);
    rd(8'h1C, v); check("R1 ctrl", v, 0);
    rd(8'hF4, v); check("R1 gien", v, 0);
    rd(8'h14, v); check("R1 poll", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) begin
        rd(VEC[i][39:32], v);
        checks++;
        if (v !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d vec %0d: got %h expected %h", VEC[i][43:40], i, v, VEC[i][31:0]);
        end
      end else wr(VEC[i][39:32], VEC[i][31:0]);
    end
    check("R9 poll pins", {30'b0, poll_en, poll_div4}, 3);
    check("R3 ch2 outputs", {29'b0, chan_on[2], chan_tx[2], 1'b0}, 0);
    check("R11 port1 pins", port_ctrl[32 +: 32], 32'h1234);

    // channel 3: on, tx, weight 1, count 4, done enable
    wr(8'h18, 3);
    wr(8'h1C, 32'h0001_0101);
    check("R3 ch3 pins", {28'b0, chan_on[3], chan_tx[3], chan_weight[7:6]}, 32'hD);
    wr(8'h24, 4);
    wr(8'h2C, 32'h08);
    pulse(3);
    check("R7 idx 1", 32'(chan_idx[3*CW +: CW]), 1);
    check("R6 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R6 irq raised", {31'b0, irq}, 1);
    rd(8'h28, v); check("R5 status set", v, 32'h08);
    wr(8'h28, 32'h0000_0081);
    rd(8'h28, v); check("R5 outside mask kept", v, 32'h08);
    wr(8'h28, 32'h7E);
    rd(8'h28, v); check("R5 acked", v, 0);
    check("R6 irq dropped", {31'b0, irq}, 0);
    pulse(3); pulse(3); pulse(3);
    check("R7 wrap", 32'(chan_idx[3*CW +: CW]), 0);
    pulse(4);
    check("R5 off channel idx", 32'(chan_idx[4*CW +: CW]), 0);
    wr(8'h18, 4);
    rd(8'h28, v); check("R5 off channel status", v, 0);
    wr(8'h18, 3);
    wr(8'hF4, 32'h0);
    pulse(3);
    @(negedge clk);
    check("R6 gated off", {31'b0, irq}, 0);
    check("R7 idx 1 again", 32'(chan_idx[3*CW +: CW]), 1);

    // R4 channel reset timing
    wr(8'h1C, 32'h0001_0103);
    for (int k = 0; k < 4; k++) begin
      check("R4 busy", {31'b0, chan_rst_busy[3]}, 1);
      if (k < 3) @(negedge clk);
    end
    @(negedge clk);
    check("R4 busy done", {31'b0, chan_rst_busy[3]}, 0);
    check("R4 on cleared", {31'b0, chan_on[3]}, 0);
    check("R4 idx cleared", 32'(chan_idx[3*CW +: CW]), 0);
    rd(8'h28, v); check("R4 status cleared", v, 0);
    rd(8'h1C, v); check("R4 fields kept", v, 32'h0001_0100);

    // R4 writes during busy ignored
    wr(8'h1C, 32'h2);
    wr(8'h1C, 32'h0002_0101);
    repeat (6) @(negedge clk);
    rd(8'h1C, v); check("R4 write in busy ignored", v, 0);

    // R10 engine reset
    wr(8'hF4, 32'hFFFF);
    wr(8'h18, 2);
    wr(8'h1C, 1);
    wr(8'h10, 1);
    @(negedge clk);
    check("R10 base cleared", chan_base[2*32 +: 32], 0);
    check("R10 on cleared", 32'(chan_on), 0);
    rd(8'hF4, v); check("R10 gien cleared", v, 0);
    rd(8'h10, v); check("R10 bit reads zero", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule